// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns a small set of control pins into the 6-bit word that sets a switched step attenuator. Bit 5 of the word carries 16 dB and each lower bit carries half the weight of the bit above it, down to 0.5 dB in bit 0. The result spans reference loss (all zeros) to 31.5 dB (all ones). A mode pin chooses between parallel and serial programming. Parallel programming runs either direct, with the latch enable held high, or latched, with the latch enable pulsed. Serial programming shifts bits into a register that sits behind a transparent latch.

All control pins are sampled on a system clock through a configurable synchronizer. Edges on the serial clock are found by comparing the synchronized value with its registered copy. Power-up is a synchronous reset. While reset is asserted, the block samples the pins to form the initial word. In serial mode, or in parallel mode with the latch enable high, that word is the parallel input. In parallel mode with the latch enable low, a two-bit preset chooses it. The serial register is loaded with the same initial word, so an early transparent phase does not disturb the output.

Top module: `step_atten_ctrl`

## Requirements
- R1: Output bit i of `atten_word` weighs 0.5 dB × 2^i. Bit 4 alone is 8 dB, bit 5 alone is 16 dB, and 6'h3F is 31.5 dB.
- R2: `ps_sel` = 0 selects the parallel inputs and `ps_sel` = 1 selects the serial register. In serial mode, changes on `par_word` never reach the output.
- R3: Direct parallel mode: with `ps_sel` = 0 and `le` = 1, the output follows `par_word`. It takes SYNC_STAGES+1 clock cycles to do so.
- R4: Latched parallel mode: while `le` = 0, the output holds. After a high pulse on `le`, it keeps the `par_word` value that was present as `le` fell.
- R5: Each rising edge of `sclk` shifts `sdata` into the 6-bit serial register, whatever the level of `le`. The first bit shifted ends up in bit 5 after six edges.
- R6: In serial mode the output tracks the serial register while `le` = 1. It freezes when `le` goes low.
- R7: When reset is released with `ps_sel` = 1, the output equals the `par_word` sampled during reset.
- R8: When reset is released with `ps_sel` = 0 and `le` = 0, `preset_sel` sets the word: 0 gives 6'h00, 1 gives 6'h10, 2 gives 6'h20 and 3 gives 6'h3F.
- R9: When reset is released with `ps_sel` = 0 and `le` = 1, the output equals `par_word` and `preset_sel` has no effect.
- R10: After reset, the output keeps its initial value until `le` goes high, even if `par_word` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, models power-up |
| ps_sel | input | 1 | 0 = parallel programming, 1 = serial programming |
| le | input | 1 | Latch enable |
| sclk | input | 1 | Serial shift clock (sampled) |
| sdata | input | 1 | Serial data, first bit is the 16 dB bit |
| par_word | input | 6 | Parallel attenuation word, also the power-up word |
| preset_sel | input | 2 | Power-up preset selector for parallel mode with `le` low |
| atten_word | output | 6 | Attenuation word to the switch array |

## Verification
The assertions assume that `sclk`, `sdata` and `le` are slow compared with the system clock. Each level must stay put long enough to pass the synchronizer, so that every serial-clock rising edge is seen exactly once and a data bit is stable on the edge that shifts it. They also assume that `sclk` is low when reset is released. The bench drives every pin on the falling clock edge. It holds each `sclk`, `sdata` and `le` level for SYNC_STAGES+3 cycles and keeps `sclk` low through every reset.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;
   typedef enum logic {
      MODE_PAR = 1'b0,
      MODE_SER = 1'b1
   } prog_mode_e;

   typedef enum logic [1:0] {
      PRE_ZERO = 2'd0,
      PRE_MID  = 2'd1,
      PRE_HIGH = 2'd2,
      PRE_MAX  = 2'd3
   } preset_e;
endpackage

// File: rtl/atten_in_sync.sv
module atten_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("atten_in_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("atten_in_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] ff;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ff <= '0;
         end else begin
            ff[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               ff[i] <= ff[i-1];
            end
         end
      end
      assign q = ff[STAGES-1];
   end
endmodule

// File: rtl/atten_powerup_sel.sv
module atten_powerup_sel
   import atten_ctrl_pkg::*;
#(
   parameter int WORD_W = 6
) (
   input  logic              mode_pin,
   input  logic              le_pin,
   input  logic [1:0]        preset,
   input  logic [WORD_W-1:0] par_in,
   output logic [WORD_W-1:0] init_word
);
   localparam logic [WORD_W-1:0] PRE_W_ZERO = '0;
   localparam logic [WORD_W-1:0] PRE_W_MID  = WORD_W'(1) << (WORD_W - 2);
   localparam logic [WORD_W-1:0] PRE_W_HIGH = WORD_W'(1) << (WORD_W - 1);
   localparam logic [WORD_W-1:0] PRE_W_MAX  = '1;

   if (WORD_W < 2) begin : g_bad_width
      $error("atten_powerup_sel: WORD_W must be at least 2");
   end

   always_comb begin
      if (prog_mode_e'(mode_pin) == MODE_SER || le_pin) begin
         init_word = par_in;
      end else begin
         unique case (preset_e'(preset))
            PRE_ZERO: init_word = PRE_W_ZERO;
            PRE_MID:  init_word = PRE_W_MID;
            PRE_HIGH: init_word = PRE_W_HIGH;
            PRE_MAX:  init_word = PRE_W_MAX;
            default:  init_word = PRE_W_ZERO;
         endcase
      end
   end
endmodule

// File: rtl/atten_serial_shift.sv
module atten_serial_shift #(
   parameter int WORD_W    = 6,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] init_word,
   input  logic              sclk_s,
   input  logic              sdata_s,
   output logic [WORD_W-1:0] shift_q
);
   logic              sclk_d;
   logic              sclk_rise;
   logic [WORD_W-1:0] shift_nx;

   if (WORD_W < 2) begin : g_bad_width
      $error("atten_serial_shift: WORD_W must be at least 2");
   end

   assign sclk_rise = sclk_s & ~sclk_d;

   if (MSB_FIRST) begin : g_msb_first
      assign shift_nx = {shift_q[WORD_W-2:0], sdata_s};
   end else begin : g_lsb_first
      assign shift_nx = {sdata_s, shift_q[WORD_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         shift_q <= init_word;
      end else begin
         sclk_d <= sclk_s;
         if (sclk_rise) begin
            shift_q <= shift_nx;
         end
      end
   end

   // R5: without a serial clock edge the register never moves
   assert_shift_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_s && !sclk_d) |=> $stable(shift_q));

   if (MSB_FIRST) begin : g_chk_msb
      // R5: a detected edge lands the data bit in the low position
      assert_shift_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (sclk_s && !sclk_d) |=> (shift_q[0] == $past(sdata_s)));
   end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
   import atten_ctrl_pkg::*;
#(
   parameter int WORD_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_sel,
   input  logic              le,
   input  logic              sclk,
   input  logic              sdata,
   input  logic [WORD_W-1:0] par_word,
   input  logic [1:0]        preset_sel,
   output logic [WORD_W-1:0] atten_word
);
   localparam int CTRL_W = WORD_W + 4;
   localparam int IX_PS  = WORD_W + 3;
   localparam int IX_LE  = WORD_W + 2;
   localparam int IX_SCK = WORD_W + 1;
   localparam int IX_SDI = WORD_W;

   if (WORD_W < 2) begin : g_bad_width
      $error("step_atten_ctrl: WORD_W must be at least 2");
   end

   logic [CTRL_W-1:0] ctrl_raw;
   logic [CTRL_W-1:0] ctrl_s;
   logic              ps_s;
   logic              le_s;
   logic [WORD_W-1:0] par_s;
   logic [WORD_W-1:0] init_w;
   logic [WORD_W-1:0] shift_w;

   assign ctrl_raw = {ps_sel, le, sclk, sdata, par_word};

   atten_in_sync #(
      .WIDTH  (CTRL_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctrl_raw),
      .q     (ctrl_s)
   );

   assign ps_s  = ctrl_s[IX_PS];
   assign le_s  = ctrl_s[IX_LE];
   assign par_s = ctrl_s[WORD_W-1:0];

   // initial word is formed from the raw pins while reset holds
   atten_powerup_sel #(
      .WORD_W (WORD_W)
   ) u_pup (
      .mode_pin  (ps_sel),
      .le_pin    (le),
      .preset    (preset_sel),
      .par_in    (par_word),
      .init_word (init_w)
   );

   atten_serial_shift #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_word (init_w),
      .sclk_s    (ctrl_s[IX_SCK]),
      .sdata_s   (ctrl_s[IX_SDI]),
      .shift_q   (shift_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         atten_word <= init_w;
      end else if (le_s) begin
         atten_word <= (prog_mode_e'(ps_s) == MODE_SER) ? shift_w : par_s;
      end
   end

   // R4 R6 R10: a low latch enable freezes the word
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !le_s |=> $stable(atten_word));

   // R3: direct parallel mode passes the parallel word
   assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ps_s && le_s) |=> (atten_word == $past(par_s)));

   // R6: transparent serial latch passes the shift register
   assert_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_s && le_s) |=> (atten_word == $past(shift_w)));
endmodule

// File: tb/step_atten_ctrl_tb_top.sv
module step_atten_ctrl_tb_top;
   localparam int W      = 6;
   localparam int STG    = 2;
   localparam int SETTLE = STG + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ps_sel = 1'b0;
   logic         le = 1'b0;
   logic         sclk = 1'b0;
   logic         sdata = 1'b0;
   logic [W-1:0] par_word = '0;
   logic [1:0]   preset_sel = 2'd0;
   logic [W-1:0] atten_word;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   step_atten_ctrl #(.WORD_W(W), .SYNC_STAGES(STG), .MSB_FIRST(1'b1)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ps_sel     (ps_sel),
      .le         (le),
      .sclk       (sclk),
      .sdata      (sdata),
      .par_word   (par_word),
      .preset_sel (preset_sel),
      .atten_word (atten_word)
   );

   task automatic check(input string tag, input logic [W-1:0] exp);
      n_chk++;
      if (atten_word !== exp) begin
         n_bad++;
         $display("FAIL %s: atten_word=%h expected=%h", tag, atten_word, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic power_up(input logic ps, input logic l, input logic [1:0] pre,
                           input logic [W-1:0] p);
      @(negedge clk);
      rst_n = 1'b0; ps_sel = ps; le = l; preset_sel = pre; par_word = p; sclk = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      sdata = b; sclk = 1'b0; settle();
      sclk = 1'b1; settle();
      sclk = 1'b0; settle();
   endtask

   task automatic pulse_le();
      le = 1'b1; settle();
      le = 1'b0; settle();
   endtask

   task automatic t_presets();
      power_up(1'b0, 1'b0, 2'd0, 6'h2A); check("R8 preset0", 6'h00);
      power_up(1'b0, 1'b0, 2'd1, 6'h2A); check("R8 R1 preset1 8dB", 6'h10);
      power_up(1'b0, 1'b0, 2'd2, 6'h2A); check("R8 R1 preset2 16dB", 6'h20);
      power_up(1'b0, 1'b0, 2'd3, 6'h2A); check("R8 R1 preset3 max", 6'h3F);
      power_up(1'b0, 1'b1, 2'd3, 6'h05); settle(); check("R9 le high ignores preset", 6'h05);
   endtask

   task automatic t_latched();
      power_up(1'b0, 1'b0, 2'd1, 6'h00);
      par_word = 6'h15; settle();
      check("R10 hold after reset", 6'h10);
      pulse_le(); check("R4 latched new word", 6'h15);
      par_word = 6'h0A; settle();
      check("R4 hold while le low", 6'h15);
   endtask

   task automatic t_direct();
      le = 1'b1; ps_sel = 1'b0;
      par_word = 6'h07; settle(); check("R3 direct follow a", 6'h07);
      par_word = 6'h38; settle(); check("R3 direct follow b", 6'h38);
      le = 1'b0; settle();
   endtask

   task automatic t_serial();
      logic [W-1:0] pat = 6'b110011;
      power_up(1'b1, 1'b0, 2'd0, 6'h2A); check("R7 serial powerup word", 6'h2A);
      for (int i = W - 1; i >= 0; i--) shift_bit(pat[i]);
      check("R5 R6 shift while le low holds", 6'h2A);
      le = 1'b1; settle(); check("R5 msb first word", 6'h33);
      par_word = 6'h01; settle(); check("R2 serial ignores parallel", 6'h33);
      shift_bit(1'b0); check("R6 transparent follows", 6'h26);
      le = 1'b0; settle();
      shift_bit(1'b1); check("R6 frozen after le low", 6'h26);
      pulse_le(); check("R5 shift with le low then latch", 6'h0D);
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_presets();
      t_latched();
      t_direct();
      t_serial();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule